// File: doc/BRIEF.md
# Store-Commit Load Ordering Violation Detector

This block keeps a small in-order queue of in-flight loads so that loads may execute before older stores have resolved their addresses. Each load takes an entry when it is dispatched, with its program-order sequence tag. When its address has been computed and its data obtained, the entry is updated with the address and a note of which store, if any, supplied the data by forwarding. Until it retires, such a load is treated as speculative.

When a store commits, its address and sequence tag are probed against the queue. Only loads younger than the store, and already executed, take part. A load whose address equals the store's, and whose data did not come from this store or from a store younger than it, read stale memory. When one or more loads fail this way, the oldest of them is reported one cycle later on the replay output. In the same clock edge the detector frees that load's entry and every entry younger than it, so the pipeline can refetch from that load onward. If nothing matches, the speculation was correct and nothing changes.

Allocation is a valid/ready stream: a load is taken on a cycle where both are high, and ready is low only while every entry is occupied. The upstream stage must then hold the load and its tag until ready returns. The execute update, store probe and retire pins are plain control inputs with no back-pressure. The replay output is a single-cycle pulse that the receiver cannot stall. DEPTH must be a power of two.

Top module: `lvd_detector`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_idx` is 0 and `replay_valid` is 0.
- R2: A load is accepted when `alloc_valid` and `alloc_ready` are both high. `alloc_idx` shows the entry it takes, and entries are handed out in order modulo DEPTH. `alloc_ready` falls exactly when DEPTH entries are held.
- R3: `retire_valid` frees the oldest held entry. A retired load is no longer compared, and retire on an empty queue has no effect.
- R4: A held entry is a candidate for a store probe when all of the following are true: it has executed (in an earlier cycle, or through an execute update in the same cycle as the probe); its address equals `st_addr` exactly; and its tag is strictly younger than `st_seq`. Tag `a` is younger than `b` when (a−b) mod 2^SEQ_W lies in 1 .. 2^(SEQ_W−1)−1. An execute update naming an empty entry is ignored.
- R5: A candidate whose data was forwarded (`exec_fwd`=1) from a store whose tag equals `st_seq`, or is younger than it, is not a violation. Forwarding from a store older than the committing one gives no exemption.
- R6: When violations exist, `replay_valid` is high for one cycle, in the cycle after the probe. It carries the entry index and tag of the violating load nearest the oldest end of the queue.
- R7: On a violation, the violating entry and all younger entries are freed. The next `alloc_idx` equals `replay_idx`, and DEPTH minus the number of older surviving loads can then be accepted.
- R8: A probe with no violation raises no replay and leaves the queue contents and pointers unchanged.
- R9: In a cycle where a probe finds a violation, an allocation (even with `alloc_ready` high) and a retire are both discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A load is offered for allocation |
| alloc_ready | output | 1 | A free entry exists |
| alloc_seq | input | SEQ_W | Program-order tag of the offered load |
| alloc_idx | output | log2(DEPTH) | Entry the offered load takes |
| exec_valid | input | 1 | A held load has executed |
| exec_idx | input | log2(DEPTH) | Entry of the executed load |
| exec_addr | input | ADDR_W | Address the load read |
| exec_fwd | input | 1 | Data came from a pending store |
| exec_fwd_seq | input | SEQ_W | Tag of the store that forwarded |
| st_valid | input | 1 | A store is committing this cycle |
| st_seq | input | SEQ_W | Tag of the committing store |
| st_addr | input | ADDR_W | Address of the committing store |
| retire_valid | input | 1 | Oldest load retires |
| replay_valid | output | 1 | Ordering violation found (one-cycle pulse) |
| replay_idx | output | log2(DEPTH) | Entry of the oldest violating load |
| replay_seq | output | SEQ_W | Tag of the oldest violating load |

## Verification
The hardest situation to reach is a probe that meets several aliasing loads at once, where some are excluded by age, by not yet having executed, or by forwarding. The bench therefore sweeps every address pattern and every executed pattern over four queued loads, with the committing store placed at each position in their order. For each case it checks the reported load and how many entries can be allocated afterwards. Tag wrap-around, an execute update arriving in the same cycle as the probe, and allocation or retirement colliding with a violation are each set up directly with single-cycle stimulus.

// File: rtl/lvd_pkg.sv
package lvd_pkg;

  // Wrap-aware age test: a is strictly younger than b within a window of
  // half the tag space.
  function automatic logic seq_younger(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned w);
    logic [31:0] d;
    logic [31:0] m;
    m = (32'd1 << w) - 32'd1;
    d = (a - b) & m;
    return (d != 32'd0) && !d[w-1];
  endfunction

  // The forwarding store is the committing store or younger than it.
  function automatic logic seq_same_or_younger(input logic [31:0] a,
                                               input logic [31:0] b,
                                               input int unsigned w);
    logic [31:0] m;
    m = (32'd1 << w) - 32'd1;
    return ((a & m) == (b & m)) || seq_younger(a, b, w);
  endfunction

endpackage

// File: rtl/lvd_ptrs.sv
module lvd_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             trunc,
  input  logic [IDX_W-1:0] trunc_off,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   count,
  output logic             full,
  output logic             empty
);

  logic [IDX_W:0] head_q;
  logic [IDX_W:0] tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop) head_q <= head_q + 1'b1;
      if (trunc)     tail_q <= head_q + {1'b0, trunc_off};
      else if (push) tail_q <= tail_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign count    = tail_q - head_q;
  assign full     = (count == (IDX_W+1)'(DEPTH));
  assign empty    = (count == '0);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (IDX_W+1)'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !trunc) |=> full);

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push && !trunc) |=> empty);

endmodule

// File: rtl/lvd_entries.sv
module lvd_entries
  import lvd_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 6,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_we,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         exec_valid,
  input  logic [IDX_W-1:0]             exec_idx,
  input  logic [ADDR_W-1:0]            exec_addr,
  input  logic                         exec_fwd,
  input  logic [SEQ_W-1:0]             exec_fwd_seq,
  input  logic [DEPTH-1:0]             clear_mask,
  input  logic                         st_valid,
  input  logic [SEQ_W-1:0]             st_seq,
  input  logic [ADDR_W-1:0]            st_addr,
  output logic [DEPTH-1:0]             match,
  output logic [DEPTH-1:0][SEQ_W-1:0]  seq_o
);

  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0]             done_q;
  logic [DEPTH-1:0]             fwd_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;
  logic [DEPTH-1:0][SEQ_W-1:0]  fseq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      fwd_q   <= '0;
      addr_q  <= '0;
      seq_q   <= '0;
      fseq_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_we && alloc_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          fwd_q[i]   <= 1'b0;
          seq_q[i]   <= alloc_seq;
        end else if (clear_mask[i]) begin
          valid_q[i] <= 1'b0;
          done_q[i]  <= 1'b0;
        end else if (exec_valid && exec_idx == IDX_W'(i) && valid_q[i]) begin
          done_q[i] <= 1'b1;
          addr_q[i] <= exec_addr;
          fwd_q[i]  <= exec_fwd;
          fseq_q[i] <= exec_fwd_seq;
        end
      end
    end
  end

  // Probe view: stored state merged with an execute update of this cycle.
  logic [DEPTH-1:0]             eff_done;
  logic [DEPTH-1:0]             eff_fwd;
  logic [DEPTH-1:0][ADDR_W-1:0] eff_addr;
  logic [DEPTH-1:0][SEQ_W-1:0]  eff_fseq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_probe
    logic upd;
    logic young;
    logic exempt;
    assign upd = exec_valid && (exec_idx == IDX_W'(g)) && valid_q[g];
    assign eff_done[g] = done_q[g] || upd;
    assign eff_fwd[g]  = upd ? exec_fwd     : fwd_q[g];
    assign eff_addr[g] = upd ? exec_addr    : addr_q[g];
    assign eff_fseq[g] = upd ? exec_fwd_seq : fseq_q[g];
    assign young  = seq_younger(32'(seq_q[g]), 32'(st_seq), SEQ_W);
    assign exempt = eff_fwd[g] &&
                    seq_same_or_younger(32'(eff_fseq[g]), 32'(st_seq), SEQ_W);
    assign match[g] = st_valid && valid_q[g] && eff_done[g] && young &&
                      (eff_addr[g] == st_addr) && !exempt;
  end

  assign seq_o = seq_q;

  // R4
  match_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> ((match & ~valid_q) == '0));

endmodule

// File: rtl/lvd_pick.sv
module lvd_pick #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] match,
  input  logic [IDX_W-1:0] head_idx,
  output logic             found,
  output logic [IDX_W-1:0] pick_off,
  output logic [IDX_W-1:0] pick_idx
);

  logic [DEPTH-1:0] rot;

  always_comb begin
    rot = '0;
    for (int i = 0; i < DEPTH; i++) rot[i] = match[head_idx + IDX_W'(i)];
    pick_off = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rot[i]) pick_off = IDX_W'(i);
    end
  end

  assign found    = |rot;
  assign pick_idx = head_idx + pick_off;

  // R6
  pick_in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> match[pick_idx]);

endmodule

// File: rtl/lvd_detector.sv
module lvd_detector #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 6,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              exec_fwd,
  input  logic [SEQ_W-1:0]  exec_fwd_seq,
  input  logic              st_valid,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              retire_valid,
  output logic              replay_valid,
  output logic [IDX_W-1:0]  replay_idx,
  output logic [SEQ_W-1:0]  replay_seq
);

  logic [IDX_W-1:0]            head_idx;
  logic [IDX_W-1:0]            tail_idx;
  logic [IDX_W:0]              count;
  logic                        full;
  logic                        empty;
  logic [DEPTH-1:0]            match;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_arr;
  logic                        found;
  logic [IDX_W-1:0]            pick_off;
  logic [IDX_W-1:0]            pick_idx;
  logic                        viol;
  logic                        push;
  logic                        pop;
  logic [DEPTH-1:0]            clear_mask;

  assign viol        = st_valid && found;
  assign alloc_ready = !full;
  assign alloc_idx   = tail_idx;
  assign push        = alloc_valid && !full && !viol;
  assign pop         = retire_valid && !empty && !viol;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      logic [IDX_W-1:0] off;
      off = IDX_W'(j) - head_idx;
      clear_mask[j] = (viol && (off >= pick_off)) ||
                      (pop && (head_idx == IDX_W'(j)));
    end
  end

  lvd_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .trunc     (viol),
    .trunc_off (pick_off),
    .head_idx  (head_idx),
    .tail_idx  (tail_idx),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  lvd_entries #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_entries (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_we     (push),
    .alloc_idx    (tail_idx),
    .alloc_seq    (alloc_seq),
    .exec_valid   (exec_valid),
    .exec_idx     (exec_idx),
    .exec_addr    (exec_addr),
    .exec_fwd     (exec_fwd),
    .exec_fwd_seq (exec_fwd_seq),
    .clear_mask   (clear_mask),
    .st_valid     (st_valid),
    .st_seq       (st_seq),
    .st_addr      (st_addr),
    .match        (match),
    .seq_o        (seq_arr)
  );

  lvd_pick #(.DEPTH(DEPTH)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match),
    .head_idx (head_idx),
    .found    (found),
    .pick_off (pick_off),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replay_valid <= 1'b0;
      replay_idx   <= '0;
      replay_seq   <= '0;
    end else begin
      replay_valid <= viol;
      if (viol) begin
        replay_idx <= pick_idx;
        replay_seq <= seq_arr[pick_idx];
      end
    end
  end

  // R6
  replay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(st_valid));

  // R7
  replay_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> (tail_idx == replay_idx));

  // R8
  quiet_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !found && !alloc_valid && !retire_valid) |=>
      (!replay_valid && $stable(tail_idx) && $stable(head_idx)));

endmodule

// File: tb/lvd_detector_bench.sv
module lvd_detector_bench;

  localparam int DEPTH  = 8;
  localparam int SEQ_W  = 6;
  localparam int ADDR_W = 12;
  localparam int IW     = 3;
  localparam logic [ADDR_W-1:0] AD_A = 12'h40A;
  localparam logic [ADDR_W-1:0] AD_B = 12'h80C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic              alloc_ready;
  logic [SEQ_W-1:0]  alloc_seq = '0;
  logic [IW-1:0]     alloc_idx;
  logic              exec_valid = 1'b0;
  logic [IW-1:0]     exec_idx = '0;
  logic [ADDR_W-1:0] exec_addr = '0;
  logic              exec_fwd = 1'b0;
  logic [SEQ_W-1:0]  exec_fwd_seq = '0;
  logic              st_valid = 1'b0;
  logic [SEQ_W-1:0]  st_seq = '0;
  logic [ADDR_W-1:0] st_addr = '0;
  logic              retire_valid = 1'b0;
  logic              replay_valid;
  logic [IW-1:0]     replay_idx;
  logic [SEQ_W-1:0]  replay_seq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lvd_detector #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_lvd_detector (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_seq(alloc_seq), .alloc_idx(alloc_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .exec_fwd(exec_fwd), .exec_fwd_seq(exec_fwd_seq),
    .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr),
    .retire_valid(retire_valid),
    .replay_valid(replay_valid), .replay_idx(replay_idx), .replay_seq(replay_seq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // All operations start at a falling edge and last one cycle.
  task automatic do_reset();
    rst_n = 1'b0;
    alloc_valid = 1'b0; exec_valid = 1'b0; st_valid = 1'b0; retire_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc_one(input int seq, output int idx);
    alloc_valid = 1'b1;
    alloc_seq   = SEQ_W'(seq);
    #1 idx = int'(alloc_idx);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic exec_one(input int idx, input logic [ADDR_W-1:0] a,
                          input bit fwd, input int fseq);
    exec_valid = 1'b1; exec_idx = IW'(idx); exec_addr = a;
    exec_fwd = fwd; exec_fwd_seq = SEQ_W'(fseq);
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  task automatic probe(input int seq, input logic [ADDR_W-1:0] a);
    st_valid = 1'b1; st_seq = SEQ_W'(seq); st_addr = a;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic retire_one();
    retire_valid = 1'b1;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic fill_count(output int n);
    n = 0;
    while (alloc_ready && n < DEPTH + 2) begin
      alloc_valid = 1'b1; alloc_seq = SEQ_W'(50);
      @(negedge clk);
      alloc_valid = 1'b0;
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int idx;
    int n;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 ready", int'(alloc_ready), 1);
    chk("R1 idx", int'(alloc_idx), 0);
    chk("R1 replay", int'(replay_valid), 0);

    // R2 in-order indices and full
    for (int k = 0; k < DEPTH; k++) begin
      alloc_one(k, idx);
      chk("R2 idx order", idx, k % DEPTH);
    end
    chk("R2 full ready", int'(alloc_ready), 0);
    retire_one();
    chk("R3 retire frees", int'(alloc_ready), 1);
    fill_count(n);
    chk("R2 one slot after retire", n, 1);

    // R3 retire on empty ignored
    do_reset();
    retire_one();
    chk("R3 empty retire idx", int'(alloc_idx), 0);
    fill_count(n);
    chk("R3 empty retire count", n, DEPTH);

    // R3 retired load no longer compared
    do_reset();
    alloc_one(10, idx); alloc_one(12, idx);
    exec_one(0, AD_A, 0, 0); exec_one(1, AD_A, 0, 0);
    retire_one();
    probe(9, AD_A);
    chk("R3 retired skipped valid", int'(replay_valid), 1);
    chk("R3 retired skipped idx", int'(replay_idx), 1);

    // R4 R6 R7 R8 sweep: address pattern x store position
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 5; s++) begin
        int ek;
        do_reset();
        for (int k = 0; k < 4; k++) alloc_one(10 + 2 * k, idx);
        for (int k = 0; k < 4; k++) exec_one(k, m[k] ? AD_A : AD_B, 0, 0);
        probe(9 + 2 * s, AD_A);
        ek = -1;
        for (int k = 3; k >= s; k--) if (m[k]) ek = k;
        chk("R4 R6 sweep valid", int'(replay_valid), (ek >= 0) ? 1 : 0);
        if (ek >= 0) begin
          chk("R6 sweep idx", int'(replay_idx), ek);
          chk("R6 sweep seq", int'(replay_seq), 10 + 2 * ek);
        end
        @(negedge clk);
        chk("R6 pulse width", int'(replay_valid), 0);
        chk("R7 R8 tail", int'(alloc_idx), (ek >= 0) ? ek : 4);
        fill_count(n);
        chk("R7 R8 free", n, DEPTH - ((ek >= 0) ? ek : 4));
      end
    end

    // R4 executed-pattern sweep
    for (int em = 0; em < 16; em++) begin
      int ek;
      do_reset();
      for (int k = 0; k < 4; k++) alloc_one(10 + 2 * k, idx);
      for (int k = 0; k < 4; k++) if (em[k]) exec_one(k, AD_A, 0, 0);
      probe(9, AD_A);
      ek = -1;
      for (int k = 3; k >= 0; k--) if (em[k]) ek = k;
      chk("R4 exec sweep valid", int'(replay_valid), (ek >= 0) ? 1 : 0);
      if (ek >= 0) chk("R4 exec sweep idx", int'(replay_idx), ek);
    end

    // R5 forwarding source sweep
    for (int st = 0; st < 3; st++) begin
      for (int fc = 0; fc < 4; fc++) begin
        int sq;
        int fq;
        int ev;
        sq = 15 + 2 * st;
        fq = 13 + 2 * fc;
        ev = (fc == 0 || fq < sq) ? 1 : 0;
        do_reset();
        alloc_one(20, idx);
        exec_one(0, AD_A, fc != 0, fq);
        probe(sq, AD_A);
        chk("R5 fwd exemption", int'(replay_valid), ev);
      end
    end

    // R4 execute update in the same cycle as the probe
    do_reset();
    alloc_one(10, idx);
    exec_valid = 1'b1; exec_idx = '0; exec_addr = AD_A; exec_fwd = 1'b0;
    probe(9, AD_A);
    exec_valid = 1'b0;
    chk("R4 same-cycle exec", int'(replay_valid), 1);

    // R4 execute to empty entry ignored
    do_reset();
    exec_one(0, AD_A, 0, 0);
    alloc_one(10, idx);
    probe(9, AD_A);
    chk("R4 empty exec ignored", int'(replay_valid), 0);

    // R4 tag wrap-around
    do_reset();
    alloc_one(60, idx); alloc_one(1, idx);
    exec_one(0, AD_A, 0, 0); exec_one(1, AD_A, 0, 0);
    probe(62, AD_A);
    chk("R4 wrap valid", int'(replay_valid), 1);
    chk("R4 wrap idx", int'(replay_idx), 1);
    chk("R4 wrap seq", int'(replay_seq), 1);

    // R9 allocation dropped in a violation cycle
    do_reset();
    alloc_one(10, idx); alloc_one(12, idx);
    exec_one(1, AD_A, 0, 0);
    alloc_valid = 1'b1; alloc_seq = SEQ_W'(14);
    probe(11, AD_A);
    alloc_valid = 1'b0;
    chk("R9 alloc dropped idx", int'(alloc_idx), 1);
    fill_count(n);
    chk("R9 alloc dropped free", n, DEPTH - 1);

    // R9 retire ignored in a violation cycle
    do_reset();
    alloc_one(10, idx); alloc_one(12, idx);
    exec_one(0, AD_B, 0, 0); exec_one(1, AD_A, 0, 0);
    retire_valid = 1'b1;
    probe(11, AD_A);
    retire_valid = 1'b0;
    chk("R9 retire ignored replay", int'(replay_idx), 1);
    fill_count(n);
    chk("R9 retire ignored free", n, DEPTH - 1);

    finish_run();
  end

endmodule